// File: doc/BRIEF.md
# Programmable Sync Word Detector

This block watches a serial bit stream in which each bit arrives with a one-cycle strobe and a per-bit quality flag. It looks in that stream for a 12-bit sync word set on a configuration input. The match does not have to be exact. Two 4-bit thresholds set the acceptance rule: a minimum number of the last 12 bits must carry the quality flag, and a minimum number of them must agree with the sync word position by position.

Once a match is found, the block latches a match flag and becomes a pass-through gate. Every later bit goes to a downstream data/strobe pair, and further sync words are ignored. A clear pulse, or dropping the enable, returns the block to searching with empty windows. The enable, thresholds, sync word and clear all come from a register block elsewhere. Input strobes must have at least one idle cycle between them.

Top module: `sync_word_detector`

## Requirements
- R1: On each accepted input strobe, the data and quality windows shift left and take the new bit at bit 0. Window bit i is compared with `sync_word` bit i, so the oldest of the 12 bits pairs with `sync_word[11]`.
- R2: A match requires the number of set quality bits in the window, counting the incoming bit, to be at least `qual_thresh`.
- R3: A match requires the number of window positions equal to `sync_word`, counting the incoming bit, to be at least `agree_thresh`.
- R4: A match requires 12 bits to have been shifted in since the last reset, clear or disable. With fewer bits there is no match, even when both thresholds are 0.
- R5: `match_flag` rises on the clock edge that samples the strobe of the completing bit. That completing bit is not forwarded.
- R6: While matched, a bit strobed at edge t appears on `out_bit` after edge t. `out_stb` is then high for exactly the one cycle after edge t+1. `out_bit` stays constant while `out_stb` is high.
- R7: While matched, further sync words have no effect. `match_flag` stays high and every strobed bit is forwarded.
- R8: A clear pulse drops `match_flag`, zeroes `out_bit` and `out_stb`, and empties both windows. An input strobe in the same cycle as the clear is discarded.
- R9: While `det_en` is 0, `match_flag`, `out_bit` and `out_stb` are 0, input strobes are ignored and the windows are held empty.
- R10: A threshold value of 13, 14 or 15 can never be met, so no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detector enable |
| sync_word | input | 12 | Programmed sync word |
| qual_thresh | input | 4 | Minimum count of quality-flagged bits |
| agree_thresh | input | 4 | Minimum count of bits agreeing with the sync word |
| clear | input | 1 | One-cycle pulse that returns the block to searching |
| in_stb | input | 1 | Input bit strobe, one cycle per bit |
| in_bit | input | 1 | Input data bit |
| in_qual | input | 1 | Input bit quality flag |
| match_flag | output | 1 | Latched sync-word-found flag |
| out_bit | output | 1 | Forwarded data bit |
| out_stb | output | 1 | Forwarded bit strobe |

## Verification
Two pairs of functions can coincide in one cycle. The first is a clear pulse together with an input strobe. The bench drives both on the same edge, then sends only 11 more word bits, and expects `match_flag` to stay low because the bit strobed with the clear must have been dropped. The second is the strobe that completes a match together with forwarding. The bench checks that `out_stb` stays low after the completing bit, and that the next strobed bit does produce a pulse. A near-exhaustive sweep of both thresholds over 0 to 13 runs against windows whose quality and agreement counts are set by arithmetic. Each verdict is compared with the two inequalities.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int SYNC_W = 12;
    localparam int CNT_W  = $clog2(SYNC_W + 1);

    typedef struct packed {
        logic [SYNC_W-1:0] data;
        logic [SYNC_W-1:0] qual;
        logic [CNT_W-1:0]  fill;
    } win_t;

    function automatic logic [CNT_W-1:0] ones(input logic [SYNC_W-1:0] v);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < SYNC_W; i++) s = s + CNT_W'(v[i]);
        return s;
    endfunction
endpackage

// File: rtl/swd_window.sv
module swd_window
    import swd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic shift,
    input  logic in_bit,
    input  logic in_qual,
    output win_t nxt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SYNC_W);

    win_t cur;

    always_comb begin
        nxt.data = {cur.data[SYNC_W-2:0], in_bit};
        nxt.qual = {cur.qual[SYNC_W-2:0], in_qual};
        nxt.fill = (cur.fill == FULL) ? FULL : cur.fill + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cur <= '0;
        end else if (shift) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/swd_eval.sv
module swd_eval
    import swd_pkg::*;
(
    input  win_t              nxt,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [CNT_W-1:0]  qual_thresh,
    input  logic [CNT_W-1:0]  agree_thresh,
    output logic              hit
);
    logic [CNT_W-1:0] agree_cnt;
    logic [CNT_W-1:0] qual_cnt;

    always_comb begin
        agree_cnt = ones(~(nxt.data ^ sync_word));
        qual_cnt  = ones(nxt.qual);
        hit = (nxt.fill == CNT_W'(SYNC_W)) &&
              (qual_cnt >= qual_thresh) &&
              (agree_cnt >= agree_thresh);
    end
endmodule

// File: rtl/swd_gate.sv
module swd_gate (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic fwd,
    input  logic in_bit,
    output logic out_bit,
    output logic out_stb
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend    <= 1'b0;
            out_stb <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            pend    <= fwd;
            out_stb <= pend;
            if (fwd) out_bit <= in_bit;
        end
    end
endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector
    import swd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [CNT_W-1:0]  qual_thresh,
    input  logic [CNT_W-1:0]  agree_thresh,
    input  logic              clear,
    input  logic              in_stb,
    input  logic              in_bit,
    input  logic              in_qual,
    output logic              match_flag,
    output logic              out_bit,
    output logic              out_stb
);
    logic flush;
    logic take;
    logic shift;
    logic fwd;
    logic hit;
    win_t nxt;

    assign flush = clear || !det_en;
    assign take  = in_stb && !flush;
    assign shift = take && !match_flag;
    assign fwd   = take && match_flag;

    swd_window u_win (
        .clk(clk), .rst(rst), .flush(flush), .shift(shift),
        .in_bit(in_bit), .in_qual(in_qual), .nxt(nxt)
    );

    swd_eval u_eval (
        .nxt(nxt), .sync_word(sync_word), .qual_thresh(qual_thresh),
        .agree_thresh(agree_thresh), .hit(hit)
    );

    swd_gate u_gate (
        .clk(clk), .rst(rst), .flush(flush), .fwd(fwd),
        .in_bit(in_bit), .out_bit(out_bit), .out_stb(out_stb)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            match_flag <= 1'b0;
        end else if (shift && hit) begin
            match_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/swd_checker.sv
module swd_checker (
    input logic clk,
    input logic rst,
    input logic det_en,
    input logic clear,
    input logic in_stb,
    input logic match_flag,
    input logic out_bit,
    input logic out_stb
);
    a_r5_rise_on_stb: assert property (@(posedge clk) disable iff (rst)
        $rose(match_flag) |-> $past(in_stb));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_stb |=> !out_stb);

    a_r6_data_steady: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> $stable(out_bit));

    a_r6_pulse_needs_match: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> match_flag);

    a_r7_latched: assert property (@(posedge clk) disable iff (rst)
        (match_flag && det_en && !clear) |=> match_flag);

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!match_flag && !out_stb && !out_bit));

    a_r9_off_zeroes: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> (!match_flag && !out_stb && !out_bit));
endmodule

bind sync_word_detector swd_checker u_chk (
    .clk(clk), .rst(rst), .det_en(det_en), .clear(clear), .in_stb(in_stb),
    .match_flag(match_flag), .out_bit(out_bit), .out_stb(out_stb)
);

// File: tb/sync_word_detector_bench.sv
module sync_word_detector_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        det_en = 1'b1;
    logic [11:0] sync_word = '0;
    logic [3:0]  qual_thresh = '0;
    logic [3:0]  agree_thresh = '0;
    logic        clear = 1'b0;
    logic        in_stb = 1'b0;
    logic        in_bit = 1'b0;
    logic        in_qual = 1'b0;
    logic        match_flag, out_bit, out_stb;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic ob, om, os1, os2;

    always #4 clk = ~clk;

    sync_word_detector u_sync_word_detector (
        .clk(clk), .rst(rst), .det_en(det_en), .sync_word(sync_word),
        .qual_thresh(qual_thresh), .agree_thresh(agree_thresh), .clear(clear),
        .in_stb(in_stb), .in_bit(in_bit), .in_qual(in_qual),
        .match_flag(match_flag), .out_bit(out_bit), .out_stb(out_stb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic q);
        @(negedge clk);
        in_stb = 1'b1; in_bit = b; in_qual = q;
        @(negedge clk);
        in_stb = 1'b0;
        ob = out_bit; om = match_flag;
        @(negedge clk); os1 = out_stb;
        @(negedge clk); os2 = out_stb;
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    // sends 12 bits; the first g agree with sw, the first q carry quality
    task automatic send_vec(input logic [11:0] sw, input int g, input int q, input bit chk11);
        for (int i = 0; i < 12; i++) begin
            send_bit((i < g) ? sw[11-i] : ~sw[11-i], i < q);
            if (chk11 && i == 10) check("R4 no match before 12 bits", om, 1'b0);
        end
    endtask

    task automatic send_word(input logic [11:0] sw, input int n);
        for (int i = 0; i < n; i++) send_bit(sw[11-i], 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] sw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset match_flag", match_flag, 1'b0);
        check("R8 reset out_stb", out_stb, 1'b0);
        check("R8 reset out_bit", out_bit, 1'b0);

        // R2 R3 R10 threshold sweep
        for (int qt = 0; qt < 14; qt++) begin
            for (int at = 0; at < 14; at++) begin
                int g, q;
                g = (qt + 2 * at) % 13;
                q = (3 * qt + at) % 13;
                sw = 12'((qt * 37 + at * 91 + 12'h5A3) & 12'hFFF);
                sync_word = sw; qual_thresh = 4'(qt); agree_thresh = 4'(at);
                do_clear();
                send_vec(sw, g, q, (qt == 0 && at == 0));
                check((qt > 12 || at > 12) ? "R10 high threshold" : "R2/R3 threshold",
                      om, (q >= qt && g >= at) ? 1'b1 : 1'b0);
            end
        end

        // R1 bit order and sliding window
        sw = 12'hA5C; sync_word = sw; qual_thresh = 4'd0; agree_thresh = 4'd12;
        do_clear();
        for (int i = 0; i < 12; i++) send_bit(sw[i], 1'b1);
        check("R1 reversed order no match", om, 1'b0);
        do_clear();
        send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b1);
        send_word(sw, 11);
        check("R1 window one bit short", om, 1'b0);
        send_bit(sw[0], 1'b1);
        check("R1 sliding match", om, 1'b1);
        check("R5 completing bit not forwarded", os1, 1'b0);

        // R6 forwarding
        for (int i = 0; i < 6; i++) begin
            logic b;
            b = 1'((i * 5 + 1) % 3 == 0);
            send_bit(b, 1'b0);
            check("R6 out_bit", ob, b);
            check("R6 out_stb pulse high", os1, 1'b1);
            check("R6 out_stb pulse low", os2, 1'b0);
        end

        // R7 further sync words ignored
        for (int i = 0; i < 12; i++) begin
            send_bit(sw[11-i], 1'b1);
            check("R7 match held", om, 1'b1);
            check("R7 still forwarded", os1, 1'b1);
        end

        // R8 clear
        do_clear();
        check("R8 clear match", match_flag, 1'b0);
        check("R8 clear out_bit", out_bit, 1'b0);
        send_word(sw, 11);
        check("R4 after clear 11 bits", om, 1'b0);
        send_bit(sw[0], 1'b1);
        check("R4 after clear 12 bits", om, 1'b1);

        // R8 clear and strobe in one cycle
        @(negedge clk);
        clear = 1'b1; in_stb = 1'b1; in_bit = sw[11]; in_qual = 1'b1;
        @(negedge clk);
        clear = 1'b0; in_stb = 1'b0;
        check("R8 clear wins match", match_flag, 1'b0);
        @(negedge clk);
        check("R8 clear wins no pulse", out_stb, 1'b0);
        for (int i = 1; i < 12; i++) send_bit(sw[11-i], 1'b1);
        check("R8 strobe with clear dropped", om, 1'b0);
        do_clear();
        send_word(sw, 12);
        check("R8 rematch", om, 1'b1);

        // R9 disable
        det_en = 1'b0;
        @(negedge clk);
        check("R9 disable match", match_flag, 1'b0);
        check("R9 disable out_bit", out_bit, 1'b0);
        send_word(sw, 12);
        check("R9 disabled no match", om, 1'b0);
        check("R9 disabled no pulse", os1, 1'b0);
        check("R9 disabled out_bit", ob, 1'b0);
        det_en = 1'b1;
        send_word(sw, 11);
        check("R9 windows emptied", om, 1'b0);
        send_bit(sw[0], 1'b1);
        check("R9 match after enable", om, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule